// File: doc/BRIEF.md
# Multidrop Addressable Scan Port

This block sits between a test access port that many boards share on a backplane (the primary side) and the scan chain of one board (the secondary side). It runs a copy of the standard 16-state test controller, clocked by the primary test clock and steered by primary TMS. While that controller rests in Test-Logic-Reset, Run-Test/Idle, Pause-DR or Pause-IR, the block reads address frames from primary TDI. Each frame bit is sent as a pair of line bits.

When a frame carries the board's own address, the block first echoes that address back on primary TDO and then connects. Once connected, primary TMS and primary TDI reach the board, and the board's scan output returns on primary TDO. These paths are pure wiring, with no register in them. A frame with any other address disconnects the port. Three reserved addresses act on every port at once: one disconnects, one forces the board controller to reset, and one sets up a shared drive mode. In that mode several boards receive the same TMS and TDI, and none of them drives primary TDO.

The 10-bit address input is split in two. The upper five bits come from the slot's geographic address and the lower five are set by the board. Tristate pads are outside the block: it gives a separate enable next to each output that may float.

Top module: `mdrop_scan_port`

## Requirements
- R1: While `ptrst_n` is low, and after it rises until a frame is accepted, both output enables are low and `stms` is 1.
- R2: Line bit pairs encode frames. "10" is a 1 and "01" is a 0. Address bits go most significant first. The frame opens with two consecutive 1s and closes with "00" after the tenth address bit. A frame carrying the address in reversed bit order does not connect the port.
- R3: A frame whose address equals `addr` makes the port drive `ptdo_en`=1 for 24 cycles. In those cycles `ptdo` carries "11", then the address as ten bit pairs most significant first, then "00". `stdo_en` stays 0 during the echo, and the port connects when the echo is complete.
- R4: While the port is connected, `stms`=`ptms`, `stdo`=`ptdi` and `ptdo`=`stdi` within the same cycle, with both enables at 1.
- R5: A frame with any other non-reserved address disconnects the port in the next cycle, with no echo.
- R6: While the port is disconnected, `stms` keeps the level `ptms` had at the last clock edge before the disconnect, whatever `ptms` does afterwards.
- R7: Address 10'h3FF disconnects the port in the same way as R5, including when it arrives while the port is connected.
- R8: Address 10'h3FE puts the port into reset. Both enables go low and `stms` is 1, whatever `ptms` is.
- R9: Address 10'h3FD received in Pause-DR or Pause-IR selects shared drive: `ptdo_en`=0, `stdo_en`=1, and `stms`/`stdo` follow `ptms`/`ptdi`. Received in any other state, it leaves the status unchanged.
- R10: A pair of "11" or "00" in an address bit position abandons the frame and leaves the status unchanged.
- R11: Frames are ignored outside the four resting states. For example, a frame shifted in Shift-DR does not disturb a connected port.
- R12: When `addr` holds a reserved value, it is never taken as the local address, so no echo is sent.
- R13: The state tracker follows the standard test controller transitions on rising `ptck`. For example, a reserved 10'h3FD frame is honoured after the path Run-Test/Idle, Select-DR, Select-IR, Capture-IR, Exit1-IR, Pause-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ptck | input | 1 | Primary test clock |
| ptrst_n | input | 1 | Primary test reset, asynchronous, active low |
| ptms | input | 1 | Primary test mode select |
| ptdi | input | 1 | Primary test data in |
| ptdo | output | 1 | Primary test data out |
| ptdo_en | output | 1 | Drive enable for `ptdo` |
| stms | output | 1 | Secondary test mode select |
| stdo | output | 1 | Secondary test data out (to the board chain) |
| stdo_en | output | 1 | Drive enable for `stdo` |
| stdi | input | 1 | Secondary test data in (from the board chain) |
| addr | input | 10 | Port address: geographic slot bits above, board bits below |

## Verification
The hardest case to reach is a disconnect that must leave `stms` low while `ptms` is driven high. To get there, the port must first be connected with TMS at 0, then dropped by a frame, and only after that can the bench raise `ptms`. The bench does this in Run-Test/Idle: it connects, sends the global disconnect, and then holds TMS high for five edges. Those edges walk the controller into Test-Logic-Reset while the bench watches `stms`. The shared drive mode in Pause-IR can only be reached through the whole IR branch of the controller, so the bench walks that path edge by edge before sending the reserved frame.

// File: rtl/mdrop_scan_port.sv
module mdrop_scan_port #(
  parameter int ADDR_W = 10
) (
  input  logic              ptck,
  input  logic              ptrst_n,
  input  logic              ptms,
  input  logic              ptdi,
  output logic              ptdo,
  output logic              ptdo_en,
  output logic              stms,
  output logic              stdo,
  output logic              stdo_en,
  input  logic              stdi,
  input  logic [ADDR_W-1:0] addr
);

  localparam int ACK_LEN = 2 * ADDR_W + 4;
  localparam int ACW = $clog2(ACK_LEN);
  localparam int AIW = $clog2(ADDR_W);
  localparam int RCW = $clog2(ADDR_W + 1);
  localparam logic [ADDR_W-1:0] A_DISC = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] A_RST  = A_DISC - 1'b1;
  localparam logic [ADDR_W-1:0] A_SYNC = A_DISC - 2'd2;

  typedef enum logic [3:0] {
    TLR, RTI, SELDR, CAPDR, SHDR, EX1DR, PADR, EX2DR, UPDR,
    SELIR, CAPIR, SHIR, EX1IR, PAIR, EX2IR, UPIR
  } tap_t;

  typedef enum logic [2:0] {S_RESET, S_OFF, S_ACK, S_ON, S_SYNC} link_t;

  tap_t  tap, tap_nx;
  link_t status;

  always_comb begin
    case (tap)
      TLR:     tap_nx = ptms ? TLR   : RTI;
      RTI:     tap_nx = ptms ? SELDR : RTI;
      SELDR:   tap_nx = ptms ? SELIR : CAPDR;
      CAPDR:   tap_nx = ptms ? EX1DR : SHDR;
      SHDR:    tap_nx = ptms ? EX1DR : SHDR;
      EX1DR:   tap_nx = ptms ? UPDR  : PADR;
      PADR:    tap_nx = ptms ? EX2DR : PADR;
      EX2DR:   tap_nx = ptms ? UPDR  : SHDR;
      UPDR:    tap_nx = ptms ? SELDR : RTI;
      SELIR:   tap_nx = ptms ? TLR   : CAPIR;
      CAPIR:   tap_nx = ptms ? EX1IR : SHIR;
      SHIR:    tap_nx = ptms ? EX1IR : SHIR;
      EX1IR:   tap_nx = ptms ? UPIR  : PAIR;
      PAIR:    tap_nx = ptms ? EX2IR : PAIR;
      EX2IR:   tap_nx = ptms ? UPIR  : SHIR;
      UPIR:    tap_nx = ptms ? SELDR : RTI;
      default: tap_nx = TLR;
    endcase
  end

  always_ff @(posedge ptck or negedge ptrst_n)
    if (!ptrst_n) tap <= TLR;
    else          tap <= tap_nx;

  logic in_pause, stay;
  assign in_pause = (tap == PADR) || (tap == PAIR);
  assign stay = ((tap == TLR) && ptms) || (((tap == RTI) || in_pause) && !ptms);

  logic              ph, first, rx_act;
  logic [RCW-1:0]    rx_n;
  logic [ADDR_W-1:0] rx_sh;
  logic [1:0]        pair;
  logic              rx_live, rx_done;

  assign pair    = {first, ptdi};
  assign rx_live = stay && (status != S_ACK);
  assign rx_done = rx_live && rx_act && ph && (rx_n == RCW'(ADDR_W)) && (pair == 2'b00);

  always_ff @(posedge ptck or negedge ptrst_n) begin
    if (!ptrst_n) begin
      ph     <= 1'b0;
      first  <= 1'b0;
      rx_act <= 1'b0;
      rx_n   <= '0;
      rx_sh  <= '0;
    end else if (!rx_live) begin
      ph     <= 1'b0;
      rx_act <= 1'b0;
    end else if (!rx_act) begin
      first <= ptdi;
      ph    <= 1'b1;
      rx_n  <= '0;
      if (ph && first && ptdi) begin
        rx_act <= 1'b1;
        ph     <= 1'b0;
      end
    end else if (!ph) begin
      first <= ptdi;
      ph    <= 1'b1;
    end else begin
      ph <= 1'b0;
      if (rx_n == RCW'(ADDR_W)) begin
        rx_act <= 1'b0;
      end else if (pair == 2'b10 || pair == 2'b01) begin
        rx_sh <= {rx_sh[ADDR_W-2:0], first};
        rx_n  <= rx_n + RCW'(1);
      end else begin
        rx_act <= 1'b0;
      end
    end
  end

  logic           local_ok;
  logic [ACW-1:0] ack_cnt;
  logic           hold;

  assign local_ok = addr < A_SYNC;

  always_ff @(posedge ptck or negedge ptrst_n) begin
    if (!ptrst_n) begin
      status  <= S_RESET;
      ack_cnt <= '0;
      hold    <= 1'b1;
    end else begin
      if (status == S_ON || status == S_SYNC) hold <= ptms;
      else if (status == S_RESET)             hold <= 1'b1;
      if (rx_done) begin
        if (rx_sh == A_DISC)                   status <= S_OFF;
        else if (rx_sh == A_RST)               status <= S_RESET;
        else if (rx_sh == A_SYNC) begin
          if (in_pause)                        status <= S_SYNC;
        end else if (local_ok && rx_sh == addr) begin
          status  <= S_ACK;
          ack_cnt <= '0;
        end else                               status <= S_OFF;
      end else if (status == S_ACK) begin
        if (!stay)                                    status <= S_OFF;
        else if (ack_cnt == ACW'(ACK_LEN - 1))        status <= S_ON;
        else                                          ack_cnt <= ack_cnt + ACW'(1);
      end
    end
  end

  logic [ACW-1:0] ack_off, ack_pos;
  logic           ack_bit;

  assign ack_off = ack_cnt - ACW'(2);
  assign ack_pos = ACW'(ADDR_W - 1) - (ack_off >> 1);

  always_comb begin
    if (ack_cnt < ACW'(2))                    ack_bit = 1'b1;
    else if (ack_cnt >= ACW'(ACK_LEN - 2))    ack_bit = 1'b0;
    else                                      ack_bit = addr[ack_pos[AIW-1:0]] ^ ack_cnt[0];
  end

  logic fwd;
  assign fwd     = (status == S_ON) || (status == S_SYNC);
  assign stms    = (status == S_RESET) ? 1'b1 : (fwd ? ptms : hold);
  assign stdo    = ptdi;
  assign stdo_en = fwd;
  assign ptdo_en = (status == S_ON) || (status == S_ACK);
  assign ptdo    = (status == S_ACK) ? ack_bit : stdi;

  assert_ack_len_R3: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (status == S_ON && $past(status) == S_ACK) |-> $past(ack_cnt) == ACW'(ACK_LEN - 1));

  assert_mismatch_quiet_R5: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (rx_done && rx_sh != addr && rx_sh < A_SYNC) |=> (!ptdo_en && !stdo_en));

  assert_hold_R6: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (status == S_OFF && !rx_done) |=> $stable(stms));

  assert_rst_high_R8: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (rx_done && rx_sh == A_RST) |=> (stms && !ptdo_en && !stdo_en));

  assert_sync_pause_R9: assert property (@(posedge ptck) disable iff (!ptrst_n)
    (status == S_SYNC && $past(status) != S_SYNC) |-> ($past(tap) == PADR || $past(tap) == PAIR));

endmodule

// File: tb/test_mdrop_scan_port.sv
module test_mdrop_scan_port;

  logic ptck = 1'b0, ptrst_n = 1'b0, ptms = 1'b1, ptdi = 1'b0, stdi = 1'b0;
  logic [9:0] addr = 10'h2A5;
  logic ptdo, ptdo_en, stms, stdo, stdo_en;

  localparam logic [9:0] MY = 10'h2A5;

  always #4 ptck = ~ptck;

  mdrop_scan_port i_mdrop_scan_port (
    .ptck(ptck), .ptrst_n(ptrst_n), .ptms(ptms), .ptdi(ptdi),
    .ptdo(ptdo), .ptdo_en(ptdo_en), .stms(stms), .stdo(stdo),
    .stdo_en(stdo_en), .stdi(stdi), .addr(addr)
  );

  // bit order: [4] ptdo_en [3] ptdo [2] stms [1] stdo_en [0] stdo
  typedef struct {
    logic [4:0] care;
    logic [4:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;

  function automatic string fname(int i);
    case (i)
      4: return "ptdo_en";
      3: return "ptdo";
      2: return "stms";
      1: return "stdo_en";
      default: return "stdo";
    endcase
  endfunction

  initial forever begin
    item_t it;
    logic [4:0] act;
    @(negedge ptck);
    #3;
    if (q.size() > 0) begin
      it  = q.pop_front();
      act = {ptdo_en, ptdo, stms, stdo_en, stdo};
      for (int i = 0; i < 5; i++) begin
        if (it.care[i]) begin
          checks++;
          if (act[i] !== it.exp[i]) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", it.tag, fname(i), act[i], it.exp[i], $time);
          end
        end
      end
    end
  end

  task automatic cyc(input logic tms, input logic tdi, input logic sdi,
                     input logic [4:0] care, input logic [4:0] exp, input string tag);
    item_t it;
    @(negedge ptck);
    ptms = tms;
    ptdi = tdi;
    stdi = sdi;
    it.care = care;
    it.exp  = exp;
    it.tag  = tag;
    q.push_back(it);
  endtask

  task automatic idle(input logic tms, input int n);
    for (int i = 0; i < n; i++) cyc(tms, 1'b0, 1'b0, 5'b00000, 5'b00000, "");
  endtask

  task automatic send(input logic [9:0] a, input logic tms);
    cyc(tms, 1'b0, 1'b0, 5'b0, 5'b0, "");
    cyc(tms, 1'b1, 1'b0, 5'b0, 5'b0, "");
    cyc(tms, 1'b1, 1'b0, 5'b0, 5'b0, "");
    for (int i = 9; i >= 0; i--) begin
      cyc(tms, a[i], 1'b0, 5'b0, 5'b0, "");
      cyc(tms, ~a[i], 1'b0, 5'b0, 5'b0, "");
    end
    cyc(tms, 1'b0, 1'b0, 5'b0, 5'b0, "");
    cyc(tms, 1'b0, 1'b0, 5'b0, 5'b0, "");
  endtask

  function automatic logic echo_bit(input int j, input logic [9:0] a);
    if (j < 2) return 1'b1;
    if (j >= 22) return 1'b0;
    return (j % 2 == 0) ? a[9 - (j - 2) / 2] : ~a[9 - (j - 2) / 2];
  endfunction

  task automatic expect_echo(input logic [9:0] a, input logic tms);
    for (int j = 0; j < 24; j++)
      cyc(tms, 1'b0, 1'b0, 5'b11010, {1'b1, echo_bit(j, a), 3'b000}, "R3");
  endtask

  bit done = 1'b0;

  initial begin
    #(8 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: under reset and right after release
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 5'b10110, 5'b00100, "R1");
    @(negedge ptck);
    ptrst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 5'b10110, 5'b00100, "R1");
    cyc(1'b0, 1'b0, 1'b0, 5'b10110, 5'b00100, "R1");

    // R2: reversed bit order is not the local address
    send(10'h295, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 5'b10110, 5'b00100, "R2");

    // R3 / R4: connect in Run-Test/Idle, then check forwarding
    send(MY, 1'b0);
    expect_echo(MY, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 5'b11111, 5'b10011, "R4");
    cyc(1'b0, 1'b0, 1'b1, 5'b11111, 5'b11010, "R4");
    cyc(1'b1, 1'b0, 1'b1, 5'b11111, 5'b11110, "R4");
    idle(1'b0, 2);

    // R11: a frame in Shift-DR is ignored
    send(10'h155, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 5'b11111, 5'b10011, "R11");
    cyc(1'b1, 1'b0, 1'b0, 5'b00000, 5'b00000, "");
    cyc(1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, "");

    // R9: shared drive in Pause-DR
    send(10'h3FD, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 5'b10111, 5'b00011, "R9");

    // R10: invalid pair in an address position abandons the frame
    cyc(1'b0, 1'b0, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b1, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b1, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b1, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b0, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b1, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b1, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b0, 1'b0, 5'b10111, 5'b00010, "R10");
    cyc(1'b0, 1'b0, 1'b0, 5'b10111, 5'b00010, "R10");

    // R5: other address disconnects at once
    send(10'h155, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 5'b10110, 5'b00000, "R5");

    // R6: stms holds low while ptms is high
    cyc(1'b1, 1'b0, 1'b0, 5'b10110, 5'b00000, "R6");
    cyc(1'b1, 1'b0, 1'b0, 5'b10110, 5'b00000, "R6");
    cyc(1'b0, 1'b0, 1'b0, 5'b00000, 5'b00000, "");

    // R9: shared-drive address outside pause leaves status as is
    send(10'h3FD, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 5'b10010, 5'b00000, "R9");
    cyc(1'b0, 1'b0, 1'b0, 5'b10010, 5'b00000, "R9");

    // R7: global disconnect from connected
    send(MY, 1'b0);
    expect_echo(MY, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 5'b10010, 5'b10010, "R3");
    send(10'h3FF, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, 5'b10110, 5'b00000, "R7");

    // R8: connect in Test-Logic-Reset, then global reset address
    send(MY, 1'b1);
    expect_echo(MY, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 5'b10110, 5'b10110, "R4");
    send(10'h3FE, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 5'b10110, 5'b00100, "R8");
    cyc(1'b0, 1'b0, 1'b0, 5'b10110, 5'b00100, "R8");

    // R12: reserved value on addr never matches
    addr = 10'h3FD;
    send(10'h3FD, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 5'b10110, 5'b00100, "R12");
    addr = MY;

    // R13: walk the IR branch to Pause-IR, then shared drive
    cyc(1'b1, 1'b0, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b1, 1'b0, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b0, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b1, 1'b0, 1'b0, 5'b0, 5'b0, "");
    cyc(1'b0, 1'b0, 1'b0, 5'b0, 5'b0, "");
    send(10'h3FD, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 5'b10111, 5'b00010, "R13");
    cyc(1'b0, 1'b1, 1'b0, 5'b10111, 5'b00011, "R13");

    idle(1'b0, 3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule